// File: doc/BRIEF.md
# Clock lane transmit sequencer

This block runs the clock lane of a serial link that has a low-power signalling mode and a high-speed mode. A level request asks the lane to start or stop the high-speed clock. The block steps through a fixed order of timed line states and presents each one to an abstracted analog front end as a small line-state code. The codes are LP-11 = 0, LP-01 = 1, LP-00 = 2, HS-0 = 3 and HS clock toggling = 4.

The block is also the point where the data lanes are coupled to the clock lane. It raises a data-lane enable only after the clock has toggled for a programmed lead-in. When the request drops, it waits until every data lane reports that it is back in low power. Only then does it run the clock-side shutdown.

Every interval is a register input counted in reference clock cycles. A register value of zero is treated as one cycle, so the order of states never changes.

Top module: `cls_tx_seq`

## Requirements
- R1: While reset is active and in the cycle after it is released, `line_code` is 0 (LP-11) and `data_en` is 0.
- R2: In the stop state, a clock edge that samples `hs_req` high moves the lane to `line_code` 1 (LP-01). The lane holds code 1 for exactly `cfg_lpx` cycles.
- R3: After LP-01, `line_code` is 2 (LP-00) for exactly `cfg_prep` cycles and then goes directly to 3 (HS-0).
- R4: HS-0 lasts exactly `cfg_zero` cycles. After it, `line_code` becomes 4 (clock toggling).
- R5: `data_en` stays 0 for the first `cfg_pre` cycles of clock toggling and then goes to 1. `data_en` is never 1 unless `line_code` is 4.
- R6: While `data_en` is 1, the lane stays in toggling with `data_en` 1 as long as `hs_req` is high or any bit of `lane_done` is low.
- R7: When `hs_req` is low and all `lane_done` bits are high, the clock keeps toggling with `data_en` 0 for exactly `cfg_post` cycles. `line_code` is then 3 (HS-0) for exactly `cfg_trail` cycles.
- R8: After the trail, `line_code` is 0 (LP-11) for exactly `cfg_exit` cycles. Requests during post, trail and exit are not acted on. A held request starts a new LP-01 only after one further stop cycle.
- R9: An interval input of 0 gives a segment of one cycle, and no segment is ever skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | Level request for high-speed clock operation |
| lane_done | input | LANES | Per data lane: lane has returned to low power |
| cfg_lpx | input | CNT_W | LP-01 length in cycles |
| cfg_prep | input | CNT_W | LP-00 prepare length in cycles |
| cfg_zero | input | CNT_W | HS-0 lead-in length in cycles |
| cfg_pre | input | CNT_W | Toggling cycles before data lanes are enabled |
| cfg_post | input | CNT_W | Toggling cycles after the data lanes finish |
| cfg_trail | input | CNT_W | HS-0 trail length in cycles |
| cfg_exit | input | CNT_W | Minimum LP-11 length after the trail |
| line_code | output | 3 | Line state for the front end (0 LP-11, 1 LP-01, 2 LP-00, 3 HS-0, 4 toggling) |
| data_en | output | 1 | Data lanes may start their move to high speed |

## Verification
The state is registered and the outputs are decoded from it. A request or release sampled at one rising edge is therefore visible on `line_code` and `data_en` straight after that edge, and each segment then lasts exactly its programmed length. The bench drives inputs and samples outputs on the falling edge. It walks a cycle-by-cycle expected trace that it builds by adding the clamped interval lengths. This places every sample half a cycle after the edge that caused it. The sweep covers many interval combinations, including all-zero values. It also holds one data lane not done while the request is low, and it re-asserts the request during shutdown.

// File: rtl/cls_pkg.sv
package cls_pkg;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_LP01,
        ST_PREP,
        ST_ZERO,
        ST_PRE,
        ST_DATA,
        ST_POST,
        ST_TRAIL,
        ST_EXIT
    } cls_state_e;

    localparam logic [2:0] LINE_LP11 = 3'd0;
    localparam logic [2:0] LINE_LP01 = 3'd1;
    localparam logic [2:0] LINE_LP00 = 3'd2;
    localparam logic [2:0] LINE_HS0  = 3'd3;
    localparam logic [2:0] LINE_HSCK = 3'd4;

endpackage

// File: rtl/cls_lane_join.sv
module cls_lane_join #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] done_i,
    output logic             all_done_o
);
    logic [LANES:0] acc;

    assign acc[0] = 1'b1;

    for (genvar g = 0; g < LANES; g++) begin : g_join
        assign acc[g+1] = acc[g] & done_i[g];
    end

    assign all_done_o = acc[LANES];
endmodule

// File: rtl/cls_len_mux.sv
module cls_len_mux
    import cls_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  cls_state_e       st_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] lpx_i,
    input  logic [CNT_W-1:0] prep_i,
    input  logic [CNT_W-1:0] zero_i,
    input  logic [CNT_W-1:0] pre_i,
    input  logic [CNT_W-1:0] post_i,
    input  logic [CNT_W-1:0] trail_i,
    input  logic [CNT_W-1:0] exit_i,
    output logic [CNT_W-1:0] len_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] raw;

    always_comb begin
        case (st_i)
            ST_LP01:  raw = lpx_i;
            ST_PREP:  raw = prep_i;
            ST_ZERO:  raw = zero_i;
            ST_PRE:   raw = pre_i;
            ST_POST:  raw = post_i;
            ST_TRAIL: raw = trail_i;
            ST_EXIT:  raw = exit_i;
            default:  raw = '0;
        endcase
    end

    // a zero register still yields one cycle in the segment
    assign len_o  = (raw == '0) ? ONE : raw;
    assign last_o = (cnt_i == (len_o - ONE));
endmodule

// File: rtl/cls_line_enc.sv
module cls_line_enc
    import cls_pkg::*;
(
    input  cls_state_e st_i,
    output logic [2:0] line_o,
    output logic       den_o
);
    always_comb begin
        den_o = 1'b0;
        case (st_i)
            ST_LP01:  line_o = LINE_LP01;
            ST_PREP:  line_o = LINE_LP00;
            ST_ZERO:  line_o = LINE_HS0;
            ST_PRE:   line_o = LINE_HSCK;
            ST_DATA: begin
                line_o = LINE_HSCK;
                den_o  = 1'b1;
            end
            ST_POST:  line_o = LINE_HSCK;
            ST_TRAIL: line_o = LINE_HS0;
            default:  line_o = LINE_LP11;
        endcase
    end
endmodule

// File: rtl/cls_tx_seq.sv
module cls_tx_seq
    import cls_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_req,
    input  logic [LANES-1:0] lane_done,
    input  logic [CNT_W-1:0] cfg_lpx,
    input  logic [CNT_W-1:0] cfg_prep,
    input  logic [CNT_W-1:0] cfg_zero,
    input  logic [CNT_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic [CNT_W-1:0] cfg_trail,
    input  logic [CNT_W-1:0] cfg_exit,
    output logic [2:0]       line_code,
    output logic             data_en
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        cls_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             all_done;
    logic             seg_last;
    logic [CNT_W-1:0] seg_len;

    cls_lane_join #(.LANES(LANES)) u_join (
        .done_i     (lane_done),
        .all_done_o (all_done)
    );

    cls_len_mux #(.CNT_W(CNT_W)) u_len (
        .st_i    (seq_q.st),
        .cnt_i   (seq_q.cnt),
        .lpx_i   (cfg_lpx),
        .prep_i  (cfg_prep),
        .zero_i  (cfg_zero),
        .pre_i   (cfg_pre),
        .post_i  (cfg_post),
        .trail_i (cfg_trail),
        .exit_i  (cfg_exit),
        .len_o   (seg_len),
        .last_o  (seg_last)
    );

    cls_line_enc u_enc (
        .st_i   (seq_q.st),
        .line_o (line_code),
        .den_o  (data_en)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.cnt = seq_q.cnt + ONE;
        case (seq_q.st)
            ST_STOP: begin
                seq_d.cnt = '0;
                if (hs_req) seq_d.st = ST_LP01;
            end
            ST_LP01: if (seg_last) begin seq_d.st = ST_PREP;  seq_d.cnt = '0; end
            ST_PREP: if (seg_last) begin seq_d.st = ST_ZERO;  seq_d.cnt = '0; end
            ST_ZERO: if (seg_last) begin seq_d.st = ST_PRE;   seq_d.cnt = '0; end
            ST_PRE:  if (seg_last) begin seq_d.st = ST_DATA;  seq_d.cnt = '0; end
            ST_DATA: begin
                seq_d.cnt = '0;
                if (!hs_req && all_done) seq_d.st = ST_POST;
            end
            ST_POST:  if (seg_last) begin seq_d.st = ST_TRAIL; seq_d.cnt = '0; end
            ST_TRAIL: if (seg_last) begin seq_d.st = ST_EXIT;  seq_d.cnt = '0; end
            ST_EXIT:  if (seg_last) begin seq_d.st = ST_STOP;  seq_d.cnt = '0; end
            default: begin
                seq_d.st  = ST_STOP;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_STOP;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R2: a request seen in stop produces LP-01 next
    a_r2_stop_to_lp01: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_STOP && hs_req) |=> (line_code == LINE_LP01));

    // R3: prepare is left only into HS-0
    a_r3_prep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (line_code == LINE_LP00) |=> (line_code == LINE_LP00 || line_code == LINE_HS0));

    // R5: enable only while the clock toggles
    a_r5_en_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> (line_code == LINE_HSCK));

    // R6: data phase held while request high or a lane not done
    a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && (hs_req || !all_done)) |=> data_en);

    // R7: post is followed only by trail
    a_r7_post_to_trail: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_POST) |=> (seq_q.st == ST_POST || seq_q.st == ST_TRAIL));

    // R8: exit ends only in stop, never straight into LP-01
    a_r8_exit_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_EXIT) |=> (seq_q.st == ST_EXIT || seq_q.st == ST_STOP));

    // R9: counter never passes the clamped segment length
    a_r9_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_STOP && seq_q.st != ST_DATA) |-> (seq_q.cnt < seg_len));
endmodule

// File: tb/cls_tx_seq_tb_top.sv
`timescale 1ns/1ps
module cls_tx_seq_tb_top;
    localparam int CNT_W = 8;
    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hs_req = 1'b0;
    logic [LANES-1:0] lane_done = '0;
    logic [CNT_W-1:0] cfg [7];
    logic [2:0]       line_code;
    logic             data_en;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    cls_tx_seq #(.CNT_W(CNT_W), .LANES(LANES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_req    (hs_req),
        .lane_done (lane_done),
        .cfg_lpx   (cfg[0]),
        .cfg_prep  (cfg[1]),
        .cfg_zero  (cfg[2]),
        .cfg_pre   (cfg[3]),
        .cfg_post  (cfg[4]),
        .cfg_trail (cfg[5]),
        .cfg_exit  (cfg[6]),
        .line_code (line_code),
        .data_en   (data_en)
    );

    function automatic int eff(input logic [CNT_W-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // wait one falling edge and compare the outputs
    task automatic step(input logic [2:0] el, input logic ee, input string tag);
        @(negedge clk);
        total++;
        if (line_code !== el || data_en !== ee) begin
            bad++;
            $display("FAIL %s t=%0t line=%0d en=%0b exp line=%0d en=%0b",
                     tag, $time, line_code, data_en, el, ee);
        end
    endtask

    task automatic run_pass(input int p);
        string t9;
        @(negedge clk);
        rst_n = 1'b0;
        hs_req = 1'b0;
        lane_done = '0;
        for (int f = 0; f < 7; f++)
            cfg[f] = (p == 0) ? '0 : CNT_W'((p * (f + 1) + p / 5) % 6);
        @(negedge clk);
        total++;
        if (line_code !== 3'd0 || data_en !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset line=%0d en=%0b exp line=0 en=0", line_code, data_en);
        end
        rst_n = 1'b1;
        step(3'd0, 1'b0, "R1");
        hs_req = 1'b1;
        lane_done = '1;
        // R9 tag where the register is zero
        t9 = (cfg[0] == 0) ? "R9" : "R2";
        for (int i = 0; i < eff(cfg[0]); i++) step(3'd1, 1'b0, t9);
        t9 = (cfg[1] == 0) ? "R9" : "R3";
        for (int i = 0; i < eff(cfg[1]); i++) step(3'd2, 1'b0, t9);
        t9 = (cfg[2] == 0) ? "R9" : "R4";
        for (int i = 0; i < eff(cfg[2]); i++) step(3'd3, 1'b0, t9);
        t9 = (cfg[3] == 0) ? "R9" : "R5";
        for (int i = 0; i < eff(cfg[3]); i++) step(3'd4, 1'b0, t9);
        for (int i = 0; i < 4; i++) step(3'd4, 1'b1, "R5");
        hs_req = 1'b0;
        lane_done = '1;
        lane_done[p % LANES] = 1'b0;
        for (int i = 0; i < 3; i++) step(3'd4, 1'b1, "R6");
        lane_done = '1;
        t9 = (cfg[4] == 0) ? "R9" : "R7";
        for (int i = 0; i < eff(cfg[4]); i++) begin
            step(3'd4, 1'b0, t9);
            if (i == 0) begin
                hs_req = 1'b1;
                lane_done = '0;
            end
        end
        t9 = (cfg[5] == 0) ? "R9" : "R7";
        for (int i = 0; i < eff(cfg[5]); i++) step(3'd3, 1'b0, t9);
        t9 = (cfg[6] == 0) ? "R9" : "R8";
        for (int i = 0; i < eff(cfg[6]); i++) step(3'd0, 1'b0, t9);
        step(3'd0, 1'b0, "R8");
        step(3'd1, 1'b0, "R8");
        hs_req = 1'b0;
    endtask

    initial begin
        for (int f = 0; f < 7; f++) cfg[f] = '0;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 64; p++) run_pass(p);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule